// File: doc/BRIEF.md
# Two-Level Interrupt Aggregation Controller

This block gathers interrupt conditions from three sections of a framer: a receive section, a transmit section and a one-second timer. Each condition arrives as a one-cycle pulse. The pulse is caught in a sticky source status bit. A source enable register decides whether that bit counts toward its section. Each section's enabled pending bits are ORed into one bit of a read-only block status byte. A block enable byte with the same bit layout then decides which sections may pull the shared active-low request pin to the host.

The host reaches all registers over a byte-wide bus with single-cycle read and write strobes. Read data is registered and appears one clock after the read strobe. A typical service routine reads the block status byte first to find the section. It then reads that section's source status registers, and each such read clears the register it returns.

Top module: `irq_hier_ctrl`

## Requirements
- R1: After reset, irq_n is 1 and every register reads 0x00.
- R2: A pulse on a condition input sets the matching source status bit whether or not that bit is enabled. The address map is: receive status at 0x14 and 0x15 (bit i of byte k is rx_evt[8k+i]), transmit status at 0x29, one-second status at 0x0B bit 0.
- R3: A read of a source status register returns its value and clears it. A condition that arrives in the same cycle as that read stays set and is returned by the next read.
- R4: The block status register at 0x05 reports the receive section in bit 7, the transmit section in bit 1 and the one-second timer in bit 0. Each bit is the OR of that section's status bits ANDed with their enables. Bits 6 to 2 read 0. A bit drops as soon as its source bits are cleared.
- R5: The block enable register at 0x04 uses bit 7 for receive, bit 1 for transmit and bit 0 for the one-second timer. Its other bits read 0. A section whose block enable bit is 0 cannot assert irq_n, but it still shows in block status.
- R6: irq_n is the inverse of the OR over (block status AND block enable). It is registered, so it changes one clock after the status or enable changes.
- R7: Writes to read-only addresses (0x05, 0x14, 0x15, 0x29, 0x0B) change nothing.
- R8: Reads of unmapped addresses return 0x00.
- R9: The source enable registers read back what was written: receive at 0x12 and 0x13, transmit at 0x28, one-second at 0x0A (bit 0 only, other bits read 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the clock after bus_rd |
| rx_evt | input | 16 | Receive-section condition pulses |
| tx_evt | input | 8 | Transmit-section condition pulses |
| sec_evt | input | 1 | One-second timer pulse |
| irq_n | output | 1 | Active-low interrupt request to the host |

## Verification
The aggregation path is driven in several ways. A condition that is latched but not enabled must show in its source register and leave block status and the pin idle. An enabled condition in each receive byte, in the transmit byte and in the timer must light its own block bit and the pin after one clock of latency. A section that is pending but blocked at block level must keep its block bit while the pin is released. A read that races a new pulse tells a correct clear-on-read apart from one that drops the new event. Writes to read-only and unmapped addresses check that status cannot be forced from the bus.

// File: rtl/irq_hier_pkg.sv
package irq_hier_pkg;

  localparam int BYTE_W = 8;

  // Bit positions within the block status and block enable bytes.
  localparam int SEC_BIT_POS = 0;
  localparam int TX_BIT_POS  = 1;
  localparam int RX_BIT_POS  = 7;

  // Next value of a sticky status byte: clear-on-read first, new pulses win.
  function automatic logic [BYTE_W-1:0] sticky_next(
    input logic [BYTE_W-1:0] cur,
    input logic [BYTE_W-1:0] evt,
    input logic              clr
  );
    return (clr ? '0 : cur) | evt;
  endfunction

  // Compose the block summary byte from the three section flags.
  function automatic logic [BYTE_W-1:0] block_byte(
    input logic rx_p,
    input logic tx_p,
    input logic sec_p
  );
    logic [BYTE_W-1:0] b;
    b = '0;
    b[RX_BIT_POS]  = rx_p;
    b[TX_BIT_POS]  = tx_p;
    b[SEC_BIT_POS] = sec_p;
    return b;
  endfunction

  // Mask of implemented block bits.
  function automatic logic [BYTE_W-1:0] block_mask();
    return block_byte(1'b1, 1'b1, 1'b1);
  endfunction

endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
  import irq_hier_pkg::*;
#(
  parameter int              W       = 8,
  parameter int              DW      = 8,
  parameter int              AW      = 8,
  parameter logic [AW-1:0]   EN_ADDR = '0,
  parameter logic [AW-1:0]   ST_ADDR = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  input  logic [W-1:0]  evt,
  output logic          pend,
  output logic          clr_hit,
  output logic [W-1:0]  st_q,
  output logic [DW-1:0] rd_val
);

  localparam int PADW = BYTE_W - W;

  logic [W-1:0] en_q;
  logic         en_hit;
  logic [BYTE_W-1:0] st_next;

  assign en_hit  = wr_en && (addr == EN_ADDR);
  assign clr_hit = rd_en && (addr == ST_ADDR);

  generate
    if (PADW > 0) begin : g_pad
      logic [BYTE_W-1:0] nx_full;
      assign nx_full = sticky_next({{PADW{1'b0}}, st_q}, {{PADW{1'b0}}, evt}, clr_hit);
      assign st_next = nx_full;
    end else begin : g_full
      assign st_next = sticky_next(st_q, evt, clr_hit);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      st_q <= '0;
    end else begin
      if (en_hit) en_q <= wdata;
      st_q <= st_next[W-1:0];
    end
  end

  assign pend = |(st_q & en_q);

  always_comb begin
    rd_val = '0;
    if (addr == EN_ADDR)      rd_val[W-1:0] = en_q;
    else if (addr == ST_ADDR) rd_val[W-1:0] = st_q;
  end

endmodule

// File: rtl/irq_blk_sum.sv
module irq_blk_sum
  import irq_hier_pkg::*;
#(
  parameter int            DW      = 8,
  parameter int            AW      = 8,
  parameter logic [AW-1:0] EN_ADDR = 8'h04,
  parameter logic [AW-1:0] ST_ADDR = 8'h05
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          rx_pend,
  input  logic          tx_pend,
  input  logic          sec_pend,
  output logic [DW-1:0] blk_st,
  output logic [DW-1:0] blk_en,
  output logic          irq_n,
  output logic [DW-1:0] rd_val
);

  logic req_now;

  assign blk_st  = block_byte(rx_pend, tx_pend, sec_pend);
  assign req_now = |(blk_st & blk_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_en <= '0;
      irq_n  <= 1'b1;
    end else begin
      if (wr_en && (addr == EN_ADDR)) blk_en <= wdata & block_mask();
      irq_n <= ~req_now;
    end
  end

  always_comb begin
    rd_val = '0;
    if (addr == EN_ADDR)      rd_val = blk_en;
    else if (addr == ST_ADDR) rd_val = blk_st;
  end

endmodule

// File: rtl/irq_hier_ctrl.sv
module irq_hier_ctrl
  import irq_hier_pkg::*;
#(
  parameter int            DW         = 8,
  parameter int            AW         = 8,
  parameter int            RX_REGS    = 2,
  parameter int            TX_W       = 8,
  parameter logic [AW-1:0] A_BLK_EN   = 8'h04,
  parameter logic [AW-1:0] A_BLK_ST   = 8'h05,
  parameter logic [AW-1:0] A_RX_EN0   = 8'h12,
  parameter logic [AW-1:0] A_RX_ST0   = 8'h14,
  parameter logic [AW-1:0] A_TX_EN    = 8'h28,
  parameter logic [AW-1:0] A_TX_ST    = 8'h29,
  parameter logic [AW-1:0] A_SEC_EN   = 8'h0A,
  parameter logic [AW-1:0] A_SEC_ST   = 8'h0B
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [AW-1:0]         bus_addr,
  input  logic [DW-1:0]         bus_wdata,
  output logic [DW-1:0]         bus_rdata,
  input  logic [RX_REGS*DW-1:0] rx_evt,
  input  logic [TX_W-1:0]       tx_evt,
  input  logic                  sec_evt,
  output logic                  irq_n
);

  localparam int N_SRC = RX_REGS + 3;
  localparam int I_TX  = RX_REGS;
  localparam int I_SEC = RX_REGS + 1;
  localparam int I_BLK = RX_REGS + 2;

  logic [DW-1:0]      rd_vals [N_SRC];
  logic [RX_REGS-1:0] rx_pend_v;
  logic               rx_pend, tx_pend, sec_pend;
  logic [DW-1:0]      rd_mux;

  // Named internal events, visible to the bound checker.
  logic [TX_W-1:0]    tx_st_w;
  logic               tx_clr_w;
  logic [DW-1:0]      blk_st_w, blk_en_w;
  logic               sec_st_w, sec_clr_w;
  logic [RX_REGS-1:0] rx_clr_v;

  generate
    for (genvar gi = 0; gi < RX_REGS; gi++) begin : g_rx
      logic [DW-1:0] st_unused;
      irq_src_bank #(
        .W(DW), .DW(DW), .AW(AW),
        .EN_ADDR(AW'(A_RX_EN0 + gi)),
        .ST_ADDR(AW'(A_RX_ST0 + gi))
      ) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(bus_wr), .rd_en(bus_rd), .addr(bus_addr),
        .wdata(bus_wdata),
        .evt(rx_evt[gi*DW +: DW]),
        .pend(rx_pend_v[gi]),
        .clr_hit(rx_clr_v[gi]),
        .st_q(st_unused),
        .rd_val(rd_vals[gi])
      );
    end
  endgenerate

  assign rx_pend = |rx_pend_v;

  irq_src_bank #(
    .W(TX_W), .DW(DW), .AW(AW), .EN_ADDR(A_TX_EN), .ST_ADDR(A_TX_ST)
  ) u_tx (
    .clk(clk), .rst_n(rst_n),
    .wr_en(bus_wr), .rd_en(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata[TX_W-1:0]),
    .evt(tx_evt),
    .pend(tx_pend),
    .clr_hit(tx_clr_w),
    .st_q(tx_st_w),
    .rd_val(rd_vals[I_TX])
  );

  irq_src_bank #(
    .W(1), .DW(DW), .AW(AW), .EN_ADDR(A_SEC_EN), .ST_ADDR(A_SEC_ST)
  ) u_sec (
    .clk(clk), .rst_n(rst_n),
    .wr_en(bus_wr), .rd_en(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata[0]),
    .evt(sec_evt),
    .pend(sec_pend),
    .clr_hit(sec_clr_w),
    .st_q(sec_st_w),
    .rd_val(rd_vals[I_SEC])
  );

  irq_blk_sum #(
    .DW(DW), .AW(AW), .EN_ADDR(A_BLK_EN), .ST_ADDR(A_BLK_ST)
  ) u_blk (
    .clk(clk), .rst_n(rst_n),
    .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .rx_pend(rx_pend), .tx_pend(tx_pend), .sec_pend(sec_pend),
    .blk_st(blk_st_w), .blk_en(blk_en_w),
    .irq_n(irq_n),
    .rd_val(rd_vals[I_BLK])
  );

  // Unmapped addresses contribute nothing, so the OR yields 0x00.
  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < N_SRC; i++) rd_mux = rd_mux | rd_vals[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

endmodule

// File: rtl/irq_hier_chk.sv
module irq_hier_chk #(
  parameter int DW   = 8,
  parameter int AW   = 8,
  parameter int TX_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_wr,
  input logic            bus_rd,
  input logic [AW-1:0]   bus_addr,
  input logic [DW-1:0]   bus_rdata,
  input logic [TX_W-1:0] tx_evt,
  input logic [TX_W-1:0] tx_st,
  input logic            tx_clr,
  input logic [DW-1:0]   blk_st,
  input logic [DW-1:0]   blk_en,
  input logic            irq_n
);

  logic addr_mapped;
  always_comb begin
    case (bus_addr)
      8'h04, 8'h05, 8'h12, 8'h13, 8'h14, 8'h15,
      8'h28, 8'h29, 8'h0A, 8'h0B: addr_mapped = 1'b1;
      default:                    addr_mapped = 1'b0;
    endcase
  end

  // R6: pin follows the enabled block summary one clock later
  a_r6_pin_latency: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_n == !$past(|(blk_st & blk_en))));

  // R5: no block enabled means no request
  a_r5_blocked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_en == '0) |=> irq_n);

  // R2: a pulse always lands in the sticky status
  a_r2_pulse_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (|tx_evt) |=> ((tx_st & $past(tx_evt)) == $past(tx_evt)));

  // R3: a read with no racing pulse empties the status
  a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_clr && tx_evt == '0) |=> (tx_st == '0));

  // R7: bus writes cannot alter status
  a_r7_status_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h29 && !tx_clr && tx_evt == '0) |=> $stable(tx_st));

  // R8: unmapped reads return zero
  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !addr_mapped) |=> (bus_rdata == '0));

endmodule

bind irq_hier_ctrl irq_hier_chk #(.DW(DW), .AW(AW), .TX_W(TX_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .tx_evt(tx_evt), .tx_st(tx_st_w), .tx_clr(tx_clr_w),
  .blk_st(blk_st_w), .blk_en(blk_en_w), .irq_n(irq_n)
);

// File: tb/sim_irq_hier_ctrl.sv
module sim_irq_hier_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0, bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [15:0] rx_evt = '0;
  logic [7:0]  tx_evt = '0;
  logic        sec_evt = 1'b0;
  logic        irq_n;

  always #4 clk = ~clk;

  irq_hier_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_evt(rx_evt), .tx_evt(tx_evt), .sec_evt(sec_evt),
    .irq_n(irq_n)
  );

  typedef struct {
    logic [7:0] v;
    string      req;
  } exp_t;

  exp_t sbq[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  logic mon_rd = 1'b0;

  // Monitor: a read strobe seen at an edge yields data compared at the next falling edge.
  always @(posedge clk) mon_rd <= bus_rd;

  always @(negedge clk) begin
    if (mon_rd) begin
      exp_t e;
      n_cmp++;
      if (sbq.size() == 0) begin
        n_bad++;
        $display("FAIL scoreboard empty: rdata=%02h expected=none", bus_rdata);
      end else begin
        e = sbq.pop_front();
        if (bus_rdata !== e.v) begin
          n_bad++;
          $display("FAIL %s: rdata=%02h expected=%02h", e.req, bus_rdata, e.v);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] ev, input string req);
    exp_t e;
    @(negedge clk);
    e.v = ev; e.req = req;
    sbq.push_back(e);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk_irq(input logic ev, input string req);
    n_cmp++;
    if (irq_n !== ev) begin
      n_bad++;
      $display("FAIL %s: irq_n=%0b expected=%0b", req, irq_n, ev);
    end
  endtask

  task automatic pulse(input logic [15:0] r, input logic [7:0] t, input logic s);
    @(negedge clk);
    rx_evt = r; tx_evt = t; sec_evt = s;
    @(negedge clk);
    rx_evt = '0; tx_evt = '0; sec_evt = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk_irq(1'b1, "R1 irq after reset");
    rd(8'h04, 8'h00, "R1 blk_en");
    rd(8'h05, 8'h00, "R1 blk_st");
    rd(8'h12, 8'h00, "R1 rx_en0");
    rd(8'h14, 8'h00, "R1 rx_st0");
    rd(8'h29, 8'h00, "R1 tx_st");

    // R9: enables read back; R5: unused block bits read 0
    wr(8'h12, 8'hA5); wr(8'h13, 8'h3C); wr(8'h28, 8'hF0); wr(8'h0A, 8'hFF);
    wr(8'h04, 8'hFF);
    rd(8'h12, 8'hA5, "R9 rx_en0");
    rd(8'h13, 8'h3C, "R9 rx_en1");
    rd(8'h28, 8'hF0, "R9 tx_en");
    rd(8'h0A, 8'h01, "R9 sec_en one bit");
    rd(8'h04, 8'h83, "R5 blk_en mask");

    // R2: disabled source still latches, no request
    pulse(16'h0002, 8'h00, 1'b0);
    @(negedge clk);
    chk_irq(1'b1, "R2 disabled source quiet");
    rd(8'h05, 8'h00, "R4 disabled source not summarized");
    rd(8'h14, 8'h02, "R2 latched disabled bit");
    rd(8'h14, 8'h00, "R3 cleared by read");

    // R4/R6: enabled receive bit; latency and fall
    pulse(16'h0001, 8'h00, 1'b0);
    chk_irq(1'b1, "R6 one-clock latency");
    @(negedge clk);
    chk_irq(1'b0, "R6 request asserted");
    rd(8'h05, 8'h80, "R4 rx in bit 7");
    rd(8'h14, 8'h01, "R2 rx byte0 bit0");
    chk_irq(1'b0, "R6 still low at clear edge");
    @(negedge clk);
    chk_irq(1'b1, "R4 released after clear");
    rd(8'h05, 8'h00, "R4 block bit dropped");

    // R4: second receive byte
    pulse(16'h0400, 8'h00, 1'b0);
    rd(8'h05, 8'h80, "R4 rx byte1 summarized");
    rd(8'h15, 8'h04, "R2 rx byte1 bit2");

    // R5: transmit pending but blocked at block level
    pulse(16'h0000, 8'h10, 1'b0);
    @(negedge clk);
    chk_irq(1'b0, "R6 tx request");
    rd(8'h05, 8'h02, "R4 tx in bit 1");
    wr(8'h04, 8'h81);
    @(negedge clk);
    chk_irq(1'b1, "R5 tx blocked");
    rd(8'h05, 8'h02, "R5 blocked section still in status");
    rd(8'h29, 8'h10, "R2 tx bit4");
    wr(8'h04, 8'h83);

    // R7: one-second source and read-only writes
    pulse(16'h0000, 8'h00, 1'b1);
    @(negedge clk);
    chk_irq(1'b0, "R6 sec request");
    wr(8'h05, 8'h00);
    rd(8'h05, 8'h01, "R7 blk_st write ignored");
    wr(8'h0B, 8'h00);
    rd(8'h0B, 8'h01, "R7 sec_st write ignored");
    rd(8'h05, 8'h00, "R4 sec bit dropped");
    wr(8'h14, 8'hFF);
    rd(8'h14, 8'h00, "R7 rx_st write ignored");

    // R3: pulse racing a clear-on-read
    pulse(16'h0000, 8'h10, 1'b0);
    begin
      exp_t e;
      @(negedge clk);
      e.v = 8'h10; e.req = "R3 read during new pulse";
      sbq.push_back(e);
      bus_rd = 1'b1; bus_addr = 8'h29; tx_evt = 8'h20;
      @(negedge clk);
      bus_rd = 1'b0; tx_evt = 8'h00;
    end
    rd(8'h29, 8'h20, "R3 racing pulse kept");
    rd(8'h29, 8'h00, "R3 empty afterwards");

    // R8: unmapped reads
    rd(8'h00, 8'h00, "R8 addr 00");
    rd(8'h7F, 8'h00, "R8 addr 7F");
    rd(8'hFF, 8'h00, "R8 addr FF");

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

endmodule